// File: doc/BRIEF.md
# CAN Controller Mode and Reset Sequencer

This block is the host-facing control and mode unit of a message-buffer CAN controller. A host reaches four word registers over a simple single-cycle register bus. The registers are a mode register, a bus-configuration register, an interrupt-mask register and a receive-mask register. From these the block drives the freeze request, the disable request and the configuration outputs that the protocol engine consumes. It also reports two read-only acknowledge flags. One says the engine is frozen with its prescaler stopped. The other says the module has gone quiet after every transfer in progress has finished.

A soft reset is started by writing 1 to a bit in the mode register. The block raises a request towards the engine's clock domain and holds it until the acknowledge comes back through a synchronizer. In that cycle it clears only the host-side state and pulses a clear strobe to the engine. It then waits for the acknowledge to fall before the status bit drops, so the host can poll the bit. Configuration fields that shape bus behaviour are write-locked unless the module is frozen or disabled, with three interrupt and recovery bits left open at all times. A supervisor-only bit makes the block refuse user-privilege accesses with a transfer-error pulse.

Top module: `cmr_ctrl_top`

Register map (word address on `host_addr`):

- Address 0, mode register:
  - bit 0: disable request.
  - bit 1: freeze request.
  - bit 2: soft-reset start and busy status.
  - bit 3: freeze acknowledge, read-only.
  - bit 4: quiet acknowledge, read-only.
  - bit 5: supervisor-only.
  - bits 12:8: highest buffer index.
- Address 1, bus-configuration register:
  - bits 7:0: prescaler divide, locked.
  - bit 8: loopback, locked.
  - bit 9: listen-only, locked.
  - bit 12: bus-off interrupt mask, open.
  - bit 13: error interrupt mask, open.
  - bit 14: manual bus-off recovery, open.
- Address 2: interrupt mask, 32 bits.
- Address 3: receive mask, bits 28:0, locked.

## Requirements
- R1: After reset the mode register reads 0x00001F00, and the bus-configuration, interrupt-mask and receive-mask registers read 0. No soft-reset, freeze or disable request is driven and `host_terr` is low.
- R2: Writing 1 to mode bit 2 makes the bit read 1 and raises `srst_req_o`. The request stays high until the remote acknowledge has passed a two-flop synchronizer, so it is high at exactly D+3 falling edges when the acknowledge arrives D cycles after the request. Bit 2 clears only after the synchronized acknowledge has fallen again.
- R3: When the synchronized acknowledge arrives, `eng_clear_o` pulses for one cycle. In that cycle the freeze request and supervisor bits are cleared, the highest buffer index returns to 0x1F and the interrupt mask is cleared. A host write to the interrupt mask in the same cycle is lost.
- R4: Soft reset leaves the disable-request bit, the bus-configuration register and the receive-mask register unchanged.
- R5: Mode bit 3 sets only while the freeze request is set and `presc_stopped_i` is high. After the freeze request is withdrawn, the bit stays set until `presc_stopped_i` falls.
- R6: Mode bit 4 sets only while the disable request is set and `xfer_busy_i` is low. Until then the disable request stays pending on `disable_req_o`.
- R7: With mode bit 5 set, a user access (`host_user`=1) pulses `host_terr`, returns read data 0 and changes no register. With the bit clear, user and supervisor accesses behave alike.
- R8: The highest buffer index (mode bits 12:8) resets to 0x1F and accepts writes only while bit 3 is set. `buf_count_o` equals the index plus one.
- R9: Prescaler, loopback, listen-only and receive-mask fields accept writes only while mode bit 3 or bit 4 is set; otherwise the old value is kept. Bus-configuration bits 12, 13 and 14 accept writes at any time.
- R10: Reserved bits read 0 whatever is written to them, and addresses 4 to 15 read 0.
- R11: Writing 1 to mode bit 2 while a soft reset is still pending starts no second cycle, so `eng_clear_o` pulses once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_user | input | 1 | 1 = user privilege, 0 = supervisor |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid in the access cycle |
| host_terr | output | 1 | Transfer-error pulse for a refused access |
| srst_req_o | output | 1 | Soft-reset request to the engine domain |
| srst_ack_i | input | 1 | Soft-reset acknowledge from the engine domain (asynchronous) |
| eng_clear_o | output | 1 | One-cycle strobe clearing engine sequencer, counters, flags and timer |
| freeze_req_o | output | 1 | Freeze request to the engine |
| disable_req_o | output | 1 | Disable request to the engine |
| presc_stopped_i | input | 1 | Engine prescaler is stopped |
| xfer_busy_i | input | 1 | A transmission or reception is in progress |
| buf_count_o | output | MB_W+1 | Number of buffers taking part, index plus one |
| presc_div_o | output | PRESC_W | Prescaler divide field |
| loopback_o | output | 1 | Loopback enable |
| listen_only_o | output | 1 | Listen-only enable |
| boff_irq_mask_o | output | 1 | Bus-off interrupt enable |
| err_irq_mask_o | output | 1 | Error interrupt enable |
| boff_manual_o | output | 1 | Manual bus-off recovery |
| rx_mask_o | output | RXM_W | Receive acceptance mask |
| irq_mask_o | output | IMASK_W | Interrupt mask |

## Verification
The collision that matters is the soft-reset clear strobe landing in the same cycle as a host write to a register that the clear resets. The bench waits on a falling edge for `eng_clear_o` to be high and drives an interrupt-mask write at once, so that both take effect on the same rising edge. It judges the outcome by reading the mask back as zero. A second overlap is a repeated start write issued while the handshake is pending. It is judged by counting exactly one clear strobe and an exact request length for the chosen remote delay.

// File: rtl/cmr_pkg.sv
// Package: shared constants and types for the CAN mode/reset sequencer.
// Assumes 32-bit host data; field positions below are the host-visible map.
package cmr_pkg;
    localparam int DATA_W   = 32;

    // word addresses
    localparam int ADR_MODE  = 0;
    localparam int ADR_BCFG  = 1;
    localparam int ADR_IMASK = 2;
    localparam int ADR_RXM   = 3;

    // mode register bit positions
    localparam int B_DIS   = 0;
    localparam int B_FRZ   = 1;
    localparam int B_SRST  = 2;
    localparam int B_FACK  = 3;
    localparam int B_LACK  = 4;
    localparam int B_PRIV  = 5;
    localparam int B_MAX   = 8;

    // bus-configuration register bit positions
    localparam int B_LOOP  = 8;
    localparam int B_LSTN  = 9;
    localparam int B_BOFFM = 12;
    localparam int B_ERRM  = 13;
    localparam int B_MANR  = 14;

    // soft-reset handshake phases
    typedef enum logic [1:0] {
        SR_IDLE  = 2'd0,
        SR_REQ   = 2'd1,
        SR_DRAIN = 2'd2
    } srst_state_e;
endpackage

// File: rtl/cmr_ack_sync.sv
// Module: multi-flop synchronizer for a single level signal from another
// clock domain. Assumes the source holds the level for several cycles.
module cmr_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            // purpose: move the level one flop further into this domain
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else if (g == 0) chain_q[g] <= async_i;
                else chain_q[g] <= chain_q[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cmr_srst_seq.sv
// Module: soft-reset request/acknowledge sequencer. Holds the request until
// the synchronized acknowledge rises, emits a one-cycle clear strobe, then
// waits for the acknowledge to fall. Assumes ack_s_i is already synchronized.
module cmr_srst_seq
    import cmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ack_s_i,
    output logic req_o,
    output logic busy_o,
    output logic clr_o
);
    srst_state_e st_q;

    // purpose: advance the four-phase handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SR_IDLE;
        end else begin
            unique case (st_q)
                SR_IDLE:  if (start_i)  st_q <= SR_REQ;
                SR_REQ:   if (ack_s_i)  st_q <= SR_DRAIN;
                SR_DRAIN: if (!ack_s_i) st_q <= SR_IDLE;
                default:  st_q <= SR_IDLE;
            endcase
        end
    end

    assign req_o  = (st_q == SR_REQ);
    assign busy_o = (st_q != SR_IDLE);
    assign clr_o  = (st_q == SR_REQ) && ack_s_i;

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_s_i) |=> req_o);
    assert_drain_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(!ack_s_i));
    assert_clear_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> !clr_o);
    assert_restart_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(!busy_o));
endmodule

// File: rtl/cmr_mode_ack.sv
// Module: freeze and quiet acknowledge flags. Freeze ack follows the engine's
// prescaler-stopped indication; quiet ack waits for transfers to drain.
// Assumes both engine inputs are already in this clock domain.
module cmr_mode_ack (
    input  logic clk,
    input  logic rst_n,
    input  logic frz_req_i,
    input  logic dis_req_i,
    input  logic presc_stopped_i,
    input  logic xfer_busy_i,
    output logic frz_ack_o,
    output logic lp_ack_o
);
    // purpose: set on frozen engine, clear only once the prescaler runs again
    always_ff @(posedge clk) begin
        if (!rst_n)                               frz_ack_o <= 1'b0;
        else if (frz_req_i && presc_stopped_i)    frz_ack_o <= 1'b1;
        else if (!frz_req_i && !presc_stopped_i)  frz_ack_o <= 1'b0;
    end

    // purpose: set once disabled and idle, clear when the request is withdrawn
    always_ff @(posedge clk) begin
        if (!rst_n)            lp_ack_o <= 1'b0;
        else if (!dis_req_i)   lp_ack_o <= 1'b0;
        else if (!xfer_busy_i) lp_ack_o <= 1'b1;
    end

    assert_frz_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frz_ack_o) |-> $past(frz_req_i && presc_stopped_i));
    assert_frz_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frz_ack_o) |-> $past(!presc_stopped_i));
    assert_lp_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lp_ack_o) |-> $past(dis_req_i && !xfer_busy_i));
endmodule

// File: rtl/cmr_regfile.sv
// Module: host register file with privilege check, freeze/disable write locks
// and partial clearing on soft reset. Assumes single-cycle host accesses.
module cmr_regfile
    import cmr_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int MB_W    = 5,
    parameter int PRESC_W = 8,
    parameter int RXM_W   = 29,
    parameter int IMASK_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_i,
    input  logic               wr_i,
    input  logic               user_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               terr_o,
    input  logic               frz_ack_i,
    input  logic               lp_ack_i,
    input  logic               srst_busy_i,
    input  logic               soft_clr_i,
    output logic               srst_start_o,
    output logic               dis_req_o,
    output logic               frz_req_o,
    output logic [MB_W-1:0]    max_buf_o,
    output logic [PRESC_W-1:0] presc_o,
    output logic               loop_o,
    output logic               listen_o,
    output logic               boff_m_o,
    output logic               err_m_o,
    output logic               man_rec_o,
    output logic [RXM_W-1:0]   rx_mask_o,
    output logic [IMASK_W-1:0] int_mask_o
);
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(ADR_MODE);
    localparam logic [ADDR_W-1:0] A_BCFG  = ADDR_W'(ADR_BCFG);
    localparam logic [ADDR_W-1:0] A_IMASK = ADDR_W'(ADR_IMASK);
    localparam logic [ADDR_W-1:0] A_RXM   = ADDR_W'(ADR_RXM);

    logic priv_q;
    logic acc_ok, wr_ok, cfg_open;
    logic wr_mode, wr_bcfg, wr_imask, wr_rxm;
    logic unused_wbits;

    assign acc_ok   = sel_i && !(user_i && priv_q);
    assign terr_o   = sel_i && user_i && priv_q;
    assign wr_ok    = acc_ok && wr_i;
    assign cfg_open = frz_ack_i || lp_ack_i;
    assign wr_mode  = wr_ok && (addr_i == A_MODE);
    assign wr_bcfg  = wr_ok && (addr_i == A_BCFG);
    assign wr_imask = wr_ok && (addr_i == A_IMASK);
    assign wr_rxm   = wr_ok && (addr_i == A_RXM);
    assign srst_start_o = wr_mode && wdata_i[B_SRST] && !srst_busy_i;
    assign unused_wbits = ^wdata_i;

    // purpose: mode register; soft reset keeps only the disable bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_req_o <= 1'b0;
            frz_req_o <= 1'b0;
            priv_q    <= 1'b0;
            max_buf_o <= {MB_W{1'b1}};
        end else if (soft_clr_i) begin
            frz_req_o <= 1'b0;
            priv_q    <= 1'b0;
            max_buf_o <= {MB_W{1'b1}};
        end else if (wr_mode) begin
            dis_req_o <= wdata_i[B_DIS];
            frz_req_o <= wdata_i[B_FRZ];
            priv_q    <= wdata_i[B_PRIV];
            if (frz_ack_i) max_buf_o <= wdata_i[B_MAX +: MB_W];
        end
    end

    // purpose: bus-configuration register; locked fields open only when frozen or quiet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_o   <= '0;
            loop_o    <= 1'b0;
            listen_o  <= 1'b0;
            boff_m_o  <= 1'b0;
            err_m_o   <= 1'b0;
            man_rec_o <= 1'b0;
        end else if (wr_bcfg) begin
            boff_m_o  <= wdata_i[B_BOFFM];
            err_m_o   <= wdata_i[B_ERRM];
            man_rec_o <= wdata_i[B_MANR];
            if (cfg_open) begin
                presc_o  <= wdata_i[PRESC_W-1:0];
                loop_o   <= wdata_i[B_LOOP];
                listen_o <= wdata_i[B_LSTN];
            end
        end
    end

    // purpose: interrupt mask; host-side, so soft reset clears it and wins over a write
    always_ff @(posedge clk) begin
        if (!rst_n)          int_mask_o <= '0;
        else if (soft_clr_i) int_mask_o <= '0;
        else if (wr_imask)   int_mask_o <= wdata_i[IMASK_W-1:0];
    end

    // purpose: receive mask; locked field untouched by soft reset
    always_ff @(posedge clk) begin
        if (!rst_n)                  rx_mask_o <= '0;
        else if (wr_rxm && cfg_open) rx_mask_o <= wdata_i[RXM_W-1:0];
    end

    // purpose: read mux; refused or unmapped reads return zero
    always_comb begin
        rdata_o = '0;
        if (sel_i && !wr_i && acc_ok) begin
            unique case (addr_i)
                A_MODE: begin
                    rdata_o[B_DIS]           = dis_req_o;
                    rdata_o[B_FRZ]           = frz_req_o;
                    rdata_o[B_SRST]          = srst_busy_i;
                    rdata_o[B_FACK]          = frz_ack_i;
                    rdata_o[B_LACK]          = lp_ack_i;
                    rdata_o[B_PRIV]          = priv_q;
                    rdata_o[B_MAX +: MB_W]   = max_buf_o;
                end
                A_BCFG: begin
                    rdata_o[PRESC_W-1:0]     = presc_o;
                    rdata_o[B_LOOP]          = loop_o;
                    rdata_o[B_LSTN]          = listen_o;
                    rdata_o[B_BOFFM]         = boff_m_o;
                    rdata_o[B_ERRM]          = err_m_o;
                    rdata_o[B_MANR]          = man_rec_o;
                end
                A_IMASK: rdata_o[IMASK_W-1:0] = int_mask_o;
                A_RXM:   rdata_o[RXM_W-1:0]   = rx_mask_o;
                default: rdata_o = '0;
            endcase
        end
    end

    assert_user_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (terr_o && wr_i && !soft_clr_i) |=>
            ($stable(int_mask_o) && $stable(rx_mask_o) && $stable(presc_o) && $stable(boff_m_o)));
    assert_maxbuf_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz_ack_i && !soft_clr_i) |=> $stable(max_buf_o));
    assert_cfg_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz_ack_i && !lp_ack_i) |=> ($stable(presc_o) && $stable(loop_o) && $stable(listen_o) && $stable(rx_mask_o)));
    assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr_i |=> (int_mask_o == '0));
endmodule

// File: rtl/cmr_ctrl_top.sv
// Module: top of the CAN controller mode and reset sequencer. Connects the
// register file, acknowledge flags, soft-reset sequencer and the synchronizer
// for the remote acknowledge. Assumes srst_ack_i comes from another domain.
module cmr_ctrl_top
    import cmr_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int MB_W        = 5,
    parameter int PRESC_W     = 8,
    parameter int RXM_W       = 29,
    parameter int IMASK_W     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_sel,
    input  logic               host_wr,
    input  logic               host_user,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               host_terr,
    output logic               srst_req_o,
    input  logic               srst_ack_i,
    output logic               eng_clear_o,
    output logic               freeze_req_o,
    output logic               disable_req_o,
    input  logic               presc_stopped_i,
    input  logic               xfer_busy_i,
    output logic [MB_W:0]      buf_count_o,
    output logic [PRESC_W-1:0] presc_div_o,
    output logic               loopback_o,
    output logic               listen_only_o,
    output logic               boff_irq_mask_o,
    output logic               err_irq_mask_o,
    output logic               boff_manual_o,
    output logic [RXM_W-1:0]   rx_mask_o,
    output logic [IMASK_W-1:0] irq_mask_o
);
    logic ack_s, srst_start, srst_busy;
    logic frz_ack, lp_ack;
    logic [MB_W-1:0] max_buf;

    cmr_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(srst_ack_i), .sync_o(ack_s)
    );

    cmr_srst_seq u_srst (
        .clk(clk), .rst_n(rst_n), .start_i(srst_start), .ack_s_i(ack_s),
        .req_o(srst_req_o), .busy_o(srst_busy), .clr_o(eng_clear_o)
    );

    cmr_mode_ack u_ack (
        .clk(clk), .rst_n(rst_n),
        .frz_req_i(freeze_req_o), .dis_req_i(disable_req_o),
        .presc_stopped_i(presc_stopped_i), .xfer_busy_i(xfer_busy_i),
        .frz_ack_o(frz_ack), .lp_ack_o(lp_ack)
    );

    cmr_regfile #(
        .ADDR_W(ADDR_W), .MB_W(MB_W), .PRESC_W(PRESC_W),
        .RXM_W(RXM_W), .IMASK_W(IMASK_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .sel_i(host_sel), .wr_i(host_wr), .user_i(host_user),
        .addr_i(host_addr), .wdata_i(host_wdata),
        .rdata_o(host_rdata), .terr_o(host_terr),
        .frz_ack_i(frz_ack), .lp_ack_i(lp_ack),
        .srst_busy_i(srst_busy), .soft_clr_i(eng_clear_o),
        .srst_start_o(srst_start),
        .dis_req_o(disable_req_o), .frz_req_o(freeze_req_o),
        .max_buf_o(max_buf),
        .presc_o(presc_div_o), .loop_o(loopback_o), .listen_o(listen_only_o),
        .boff_m_o(boff_irq_mask_o), .err_m_o(err_irq_mask_o), .man_rec_o(boff_manual_o),
        .rx_mask_o(rx_mask_o), .int_mask_o(irq_mask_o)
    );

    assign buf_count_o = {1'b0, max_buf} + {{MB_W{1'b0}}, 1'b1};
endmodule

// File: tb/cmr_ctrl_top_tb.sv
`timescale 1ns/1ps
module cmr_ctrl_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 0, host_wr = 0, host_user = 0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_terr;
    logic        srst_req_o, srst_ack_i = 1'b0, eng_clear_o;
    logic        freeze_req_o, disable_req_o;
    logic        presc_stopped_i = 1'b0, xfer_busy_i = 1'b0;
    logic [5:0]  buf_count_o;
    logic [7:0]  presc_div_o;
    logic        loopback_o, listen_only_o, boff_irq_mask_o, err_irq_mask_o, boff_manual_o;
    logic [28:0] rx_mask_o;
    logic [31:0] irq_mask_o;

    int total = 0, bad = 0;
    bit auto_eng = 1'b0, mon_on = 1'b0;
    int req_cnt = 0, clr_cnt = 0;
    localparam int RDLY = 5;

    always #4 clk = ~clk;

    cmr_ctrl_top dut_i (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_user(host_user), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_terr(host_terr),
        .srst_req_o(srst_req_o), .srst_ack_i(srst_ack_i), .eng_clear_o(eng_clear_o),
        .freeze_req_o(freeze_req_o), .disable_req_o(disable_req_o),
        .presc_stopped_i(presc_stopped_i), .xfer_busy_i(xfer_busy_i),
        .buf_count_o(buf_count_o), .presc_div_o(presc_div_o),
        .loopback_o(loopback_o), .listen_only_o(listen_only_o),
        .boff_irq_mask_o(boff_irq_mask_o), .err_irq_mask_o(err_irq_mask_o),
        .boff_manual_o(boff_manual_o), .rx_mask_o(rx_mask_o), .irq_mask_o(irq_mask_o)
    );

    // engine model: prescaler stops one half-cycle after a freeze request
    always @(negedge clk) if (auto_eng) presc_stopped_i <= freeze_req_o;

    // monitor: request length and clear strobes during the soft-reset test
    always @(negedge clk) if (mon_on) begin
        if (srst_req_o)  req_cnt++;
        if (eng_clear_o) clr_cnt++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input bit wr, input bit usr, input logic [3:0] a,
                          input logic [31:0] d, output logic [31:0] rd, output logic te);
        @(negedge clk);
        host_sel = 1; host_wr = wr; host_user = usr; host_addr = a; host_wdata = d;
        #1; rd = host_rdata; te = host_terr;
        @(posedge clk); #1;
        host_sel = 0; host_wr = 0; host_user = 0;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        logic [31:0] rd; logic te;
        bus_op(1'b1, 1'b0, a, d, rd, te);
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] rd);
        logic te;
        bus_op(1'b0, 1'b0, a, 32'h0, rd, te);
    endtask

    task automatic remote(input int d);
        while (!srst_req_o) @(negedge clk);
        repeat (d) @(negedge clk);
        srst_ack_i = 1'b1;
        while (srst_req_o) @(negedge clk);
        repeat (d) @(negedge clk);
        srst_ack_i = 1'b0;
    endtask

    // vector: kind(2) 0 idle 1 write 2 read | user | addr(4) | data(32) | exp_terr | exp_rdata(32) | req(8)
    localparam int NV = 27;
    localparam logic [79:0] VEC [NV] = '{
        {2'd1,1'b0,4'h1,32'h000073FF,1'b0,32'h0,8'd9},        // R9 locked dropped, open bits kept
        {2'd2,1'b0,4'h1,32'h0,1'b0,32'h00007000,8'd9},        // R9
        {2'd1,1'b0,4'h0,32'h00000002,1'b0,32'h0,8'd5},        // R5 freeze request
        {2'd0,1'b0,4'h0,32'h0,1'b0,32'h0,8'd5},
        {2'd2,1'b0,4'h0,32'h0,1'b0,32'h00001F0A,8'd5},        // R5 frozen, R8 index kept
        {2'd1,1'b0,4'h0,32'h00000502,1'b0,32'h0,8'd8},        // R8 index write while frozen
        {2'd2,1'b0,4'h0,32'h0,1'b0,32'h0000050A,8'd8},
        {2'd1,1'b0,4'h1,32'h00000345,1'b0,32'h0,8'd9},        // R9 unlocked by freeze
        {2'd2,1'b0,4'h1,32'h0,1'b0,32'h00000345,8'd9},
        {2'd1,1'b0,4'h3,32'h12345678,1'b0,32'h0,8'd9},
        {2'd2,1'b0,4'h3,32'h0,1'b0,32'h12345678,8'd9},
        {2'd1,1'b0,4'h0,32'h00000522,1'b0,32'h0,8'd7},        // R7 supervisor-only on
        {2'd2,1'b1,4'h0,32'h0,1'b1,32'h0,8'd7},               // R7 user read refused
        {2'd1,1'b1,4'h2,32'h0000FFFF,1'b1,32'h0,8'd7},        // R7 user write refused
        {2'd2,1'b0,4'h2,32'h0,1'b0,32'h0,8'd7},
        {2'd1,1'b0,4'h2,32'hA5A50F0F,1'b0,32'h0,8'd7},
        {2'd2,1'b0,4'h2,32'h0,1'b0,32'hA5A50F0F,8'd7},
        {2'd1,1'b0,4'h0,32'h00000500,1'b0,32'h0,8'd5},        // R5 release freeze, priv off
        {2'd0,1'b0,4'h0,32'h0,1'b0,32'h0,8'd5},
        {2'd1,1'b1,4'h1,32'h000010FF,1'b0,32'h0,8'd9},        // R7 user ok, R9 locked again
        {2'd2,1'b1,4'h1,32'h0,1'b0,32'h00001345,8'd9},
        {2'd1,1'b0,4'h0,32'h00000900,1'b0,32'h0,8'd8},        // R8 index locked
        {2'd2,1'b0,4'h0,32'h0,1'b0,32'h00000500,8'd8},
        {2'd1,1'b0,4'h0,32'hFFFFE0C0,1'b0,32'h0,8'd10},       // R10 reserved bits only
        {2'd2,1'b0,4'h0,32'h0,1'b0,32'h00000500,8'd10},
        {2'd2,1'b0,4'h7,32'h0,1'b0,32'h0,8'd10},              // R10 unmapped
        {2'd2,1'b0,4'hF,32'h0,1'b0,32'h0,8'd10}
    };

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog all-reqs act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd; logic te; int k;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 srst_req", {31'b0, srst_req_o}, 32'h0);
        chk("R1 freeze/disable", {30'b0, freeze_req_o, disable_req_o}, 32'h0);
        rd_reg(4'h0, rd); chk("R1 mode", rd, 32'h00001F00);
        rd_reg(4'h1, rd); chk("R1 bcfg", rd, 32'h0);
        rd_reg(4'h2, rd); chk("R1 imask", rd, 32'h0);
        rd_reg(4'h3, rd); chk("R1 rxmask", rd, 32'h0);
        chk("R8 count at reset", {26'b0, buf_count_o}, 32'd32);

        // table walk
        auto_eng = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [79:0] v;
            v = VEC[i];
            if (v[79:78] == 2'd0) begin
                @(negedge clk);
            end else begin
                bus_op(v[79:78] == 2'd1, v[77], v[76:73], v[72:41], rd, te);
                chk($sformatf("R%0d vec%0d terr", v[7:0], i), {31'b0, te}, {31'b0, v[40]});
                if (v[79:78] == 2'd2)
                    chk($sformatf("R%0d vec%0d rdata", v[7:0], i), rd, v[39:8]);
            end
        end
        chk("R8 count=index+1", {26'b0, buf_count_o}, 32'd6);

        // R5 freeze ack follows prescaler
        auto_eng = 1'b0; presc_stopped_i = 1'b0;
        wr_reg(4'h0, 32'h00000502);
        repeat (3) @(negedge clk);
        rd_reg(4'h0, rd); chk("R5 no ack while prescaler runs", rd, 32'h00000502);
        chk("R5 freeze_req_o", {31'b0, freeze_req_o}, 32'h1);
        presc_stopped_i = 1'b1;
        repeat (2) @(negedge clk);
        rd_reg(4'h0, rd); chk("R5 ack set", rd, 32'h0000050A);
        wr_reg(4'h0, 32'h00000500);
        repeat (3) @(negedge clk);
        rd_reg(4'h0, rd); chk("R5 ack held while stopped", rd, 32'h00000508);
        presc_stopped_i = 1'b0;
        repeat (2) @(negedge clk);
        rd_reg(4'h0, rd); chk("R5 ack cleared", rd, 32'h00000500);

        // R6 quiet ack waits for transfers
        xfer_busy_i = 1'b1;
        wr_reg(4'h0, 32'h00000501);
        repeat (3) @(negedge clk);
        rd_reg(4'h0, rd); chk("R6 pending while busy", rd, 32'h00000501);
        chk("R6 disable_req_o", {31'b0, disable_req_o}, 32'h1);
        xfer_busy_i = 1'b0;
        repeat (2) @(negedge clk);
        rd_reg(4'h0, rd); chk("R6 ack set", rd, 32'h00000511);
        wr_reg(4'h1, 32'h00000055);
        rd_reg(4'h1, rd); chk("R9 unlocked by quiet", rd, 32'h00000055);
        wr_reg(4'h3, 32'hFFFFFFFF);
        rd_reg(4'h3, rd); chk("R10 rxmask reserved", rd, 32'h1FFFFFFF);
        wr_reg(4'h3, 32'h0ABCDEF0);

        // R2 R3 R4 R11 soft reset
        wr_reg(4'h2, 32'hDEADBEEF);
        wr_reg(4'h0, 32'h00000521);
        rd_reg(4'h0, rd); chk("R3 pre-state", rd, 32'h00000531);
        mon_on = 1'b1;
        fork remote(RDLY); join_none
        wr_reg(4'h0, 32'h00000525);
        rd_reg(4'h0, rd); chk("R2 bit set while pending", rd, 32'h00000535);
        wr_reg(4'h0, 32'h00000525);   // R11 second start while pending
        k = 0;
        while (!eng_clear_o && k < 100) begin @(negedge clk); k++; end
        chk("R3 clear strobe seen", {31'b0, eng_clear_o}, 32'h1);
        host_sel = 1; host_wr = 1; host_user = 0; host_addr = 4'h2; host_wdata = 32'h11111111;
        @(posedge clk); #1;
        host_sel = 0; host_wr = 0;
        k = 0;
        do begin rd_reg(4'h0, rd); k++; end while (rd[2] && k < 60);
        chk("R2 bit cleared", {31'b0, rd[2]}, 32'h0);
        chk("R3 R4 mode after reset", rd, 32'h00001F11);
        rd_reg(4'h2, rd); chk("R3 imask cleared, write lost", rd, 32'h0);
        rd_reg(4'h1, rd); chk("R4 bcfg kept", rd, 32'h00000055);
        rd_reg(4'h3, rd); chk("R4 rxmask kept", rd, 32'h0ABCDEF0);
        chk("R11 single clear strobe", clr_cnt, 32'd1);
        chk("R2 request length", req_cnt, RDLY + 3);
        chk("R2 request dropped", {31'b0, srst_req_o}, 32'h0);
        chk("R8 count after reset", {26'b0, buf_count_o}, 32'd32);
        mon_on = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule